// File: doc/BRIEF.md
# Banked Event Interrupt Aggregator

This block gathers 96 single-bit event inputs from peripherals into three 32-bit sticky status words. Three independent enable groups, each 96 bits wide, filter the same status store. Each group drives one interrupt line toward the processor. Line 0 carries the highest priority level, line 1 the middle level and line 2 the lowest. Software acknowledges an event by writing a one to its status bit.

Each line also reports a first-pending index. It scans only the status word whose number equals the line number, ANDed with the same-numbered word of that line's enable group. It returns the lowest set bit position plus 32 times the line number, together with a valid flag. The interrupt handler can then branch straight to the right event without scanning in software. Access is through a single-cycle register port: writes take effect at the clock edge, and reads return data combinationally from the address.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset, every status word, every enable word, all interrupt lines and all index valid flags read as zero.
- R2: An event input that is high at a clock edge sets its status bit. Event e lives in status word e/32 (offset 0x00, 0x04 or 0x08) at bit e%32. The bit stays set until software clears it.
- R3: Writing a status word clears each bit written as 1. Bits written as 0 keep their value.
- R4: If an event input is high in the same cycle as a write that clears its bit, the bit stays 1. Other bits cleared by that write still clear.
- R5: Enable group g word w sits at offset 0x10*(g+1) + 4*w and reads back what was last written. A write touches no other word.
- R6: Interrupt line g (bit g of `irq_o`) goes high one clock after any status bit and its enable bit in group g are both set. It goes low one clock after no such pair remains.
- R7: Clearing an enable bit removes that event's contribution to the line but leaves its status bit set.
- R8: Index g is the lowest position j set in (status word g AND group g word g), reported as j + 32*g with its valid flag. The valid flag is 0 when that masked word is zero, even if the line is high from another word. The index updates in the same cycle as the line. It is on `hint_idx_o[7g+6:7g]` and `hint_vld_o[g]`, and is readable at offset 0x40 + 4*g with the valid flag in bit 8 and the index in bits 6:0.
- R9: Reads of any offset not listed above, including unaligned ones, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 96 | Event inputs; a high level at an edge sets the status bit |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 3 | Registered interrupt lines, bit 0 highest priority |
| hint_vld_o | output | 3 | Per-line first-pending valid flag |
| hint_idx_o | output | 21 | Per-line first-pending event number, 7 bits per line |

## Verification
An event arriving and a software acknowledge of the same status bit can land on one clock edge. Directed stimulus raises event 34 in exactly the cycle that carries a write of ones to status word 1. That write also covers an already pending event 35. The bench then reads the word back and expects bit 2 still set and bit 3 cleared. A plain acknowledge follows, confirming that the surviving bit can still be cleared.

// File: rtl/evt_hub_pkg.sv
package evt_hub_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_ENAB = 2'd2,
    SEL_HINT = 2'd3
  } reg_sel_e;

  localparam int HINT_VLD_BIT = 8;

endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_en,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] stat_o
);

  logic [W-1:0] stat_q;
  logic [W-1:0] stat_n;
  logic [W-1:0] clr_vec;

  always_comb begin
    clr_vec = clr_en ? clr_data : '0;
    stat_n  = (stat_q & ~clr_vec) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_n;
  end

  assign stat_o = stat_q;

  AST_EVT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R4

  AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R2

endmodule

// File: rtl/evt_enable_word.sv
module evt_enable_word #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] enab_o
);

  logic [W-1:0] enab_q;
  logic [W-1:0] enab_n;

  always_comb begin
    enab_n = enab_q;
    if (wr_en) enab_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enab_q <= '0;
    else        enab_q <= enab_n;
  end

  assign enab_o = enab_q;

  AST_ENAB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(enab_q)); // R5

endmodule

// File: rtl/evt_line_scan.sv
module evt_line_scan #(
  parameter int W     = 32,
  parameter int BANKS = 3,
  parameter int LINE  = 0,
  parameter int IDX_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BANKS*W-1:0] stat_all,
  input  logic [BANKS*W-1:0] enab_all,
  output logic               irq_o,
  output logic               vld_o,
  output logic [IDX_W-1:0]   idx_o
);

  localparam int LO = LINE * W;
  localparam int HI = LINE * W + W;

  logic [BANKS*W-1:0] live_all;
  logic [W-1:0]       live_word;
  logic               irq_n, vld_n;
  logic [IDX_W-1:0]   idx_n;
  logic               irq_q, vld_q;
  logic [IDX_W-1:0]   idx_q;

  always_comb begin
    live_all  = stat_all & enab_all;
    live_word = live_all[LO +: W];
    irq_n     = |live_all;
    vld_n     = |live_word;
    idx_n     = '0;
    for (int j = W - 1; j >= 0; j--) begin
      if (live_word[j]) idx_n = IDX_W'(LO + j);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      irq_q <= irq_n;
      vld_q <= vld_n;
      idx_q <= idx_n;
    end
  end

  assign irq_o = irq_q;
  assign vld_o = vld_q;
  assign idx_o = idx_q;

  AST_HINT_IMPLIES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> irq_q); // R8

  AST_HINT_IN_OWN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ((int'(idx_q) >= LO) && (int'(idx_q) < HI))); // R8

  AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_all & enab_all) == '0) |=> !irq_q); // R6

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub #(
  parameter int BANKS = 3,
  parameter int W     = 32,
  parameter int AW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [BANKS*W-1:0]         evt_i,
  input  logic [AW-1:0]              bus_addr,
  input  logic                       bus_we,
  input  logic [W-1:0]               bus_wdata,
  output logic [W-1:0]               bus_rdata,
  output logic [BANKS-1:0]           irq_o,
  output logic [BANKS-1:0]           hint_vld_o,
  output logic [BANKS*$clog2(BANKS*W)-1:0] hint_idx_o
);
  import evt_hub_pkg::*;

  localparam int IDX_W  = $clog2(BANKS * W);
  localparam int REG_HI = BANKS + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // address decode
  reg_sel_e   sel;
  int         grp;
  int         wsel;
  logic [3:0] region;

  always_comb begin
    region = bus_addr[7:4];
    wsel   = int'(bus_addr[3:2]);
    grp    = 0;
    sel    = SEL_NONE;
    if (bus_addr[1:0] == 2'b00 && wsel < BANKS) begin
      if (region == 4'd0) begin
        sel = SEL_STAT;
      end else if (int'(region) <= BANKS) begin
        sel = SEL_ENAB;
        grp = int'(region) - 1;
      end else if (int'(region) == REG_HI) begin
        sel = SEL_HINT;
      end
    end
  end

  logic [BANKS*W-1:0] stat_all;
  logic [BANKS*W-1:0] enab_grp [BANKS];

  genvar b, g;
  generate
    for (b = 0; b < BANKS; b++) begin : g_stat
      logic clr_hit;
      assign clr_hit = bus_we && (sel == SEL_STAT) && (wsel == b);
      evt_status_bank #(.W(W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .evt_i    (evt_i[b*W +: W]),
        .clr_en   (clr_hit),
        .clr_data (bus_wdata),
        .stat_o   (stat_all[b*W +: W])
      );
    end

    for (g = 0; g < BANKS; g++) begin : g_grp
      for (b = 0; b < BANKS; b++) begin : g_word
        logic wr_hit;
        assign wr_hit = bus_we && (sel == SEL_ENAB) && (grp == g) && (wsel == b);
        evt_enable_word #(.W(W)) u_enab (
          .clk     (clk),
          .rst_n   (rst_sync_n),
          .wr_en   (wr_hit),
          .wr_data (bus_wdata),
          .enab_o  (enab_grp[g][b*W +: W])
        );
      end

      evt_line_scan #(.W(W), .BANKS(BANKS), .LINE(g), .IDX_W(IDX_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .stat_all (stat_all),
        .enab_all (enab_grp[g]),
        .irq_o    (irq_o[g]),
        .vld_o    (hint_vld_o[g]),
        .idx_o    (hint_idx_o[g*IDX_W +: IDX_W])
      );
    end
  endgenerate

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_STAT: bus_rdata = stat_all[wsel*W +: W];
      SEL_ENAB: bus_rdata = enab_grp[grp][wsel*W +: W];
      SEL_HINT: begin
        bus_rdata[HINT_VLD_BIT]  = hint_vld_o[wsel];
        bus_rdata[IDX_W-1:0]     = hint_idx_o[wsel*IDX_W +: IDX_W];
      end
      default:  bus_rdata = '0;
    endcase
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    (!rst_sync_n) |=> (irq_o == '0 || !rst_sync_n)); // R1

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0)); // R9

endmodule

// File: tb/evt_irq_hub_bench.sv
module evt_irq_hub_bench;

  localparam int BANKS = 3;
  localparam int W     = 32;
  localparam int IDX_W = 7;

  logic                   clk;
  logic                   rst_n;
  logic [BANKS*W-1:0]     evt;
  logic [7:0]             addr;
  logic                   we;
  logic [W-1:0]           wdata;
  logic [W-1:0]           rdata;
  logic [BANKS-1:0]       irq;
  logic [BANKS-1:0]       hvld;
  logic [BANKS*IDX_W-1:0] hidx;

  int n_chk;
  int n_bad;

  evt_irq_hub u_evt_irq_hub (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt),
    .bus_addr   (addr),
    .bus_we     (we),
    .bus_wdata  (wdata),
    .bus_rdata  (rdata),
    .irq_o      (irq),
    .hint_vld_o (hvld),
    .hint_idx_o (hidx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic fire(input int e);
    @(negedge clk);
    evt[e] = 1'b1;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clean();
    for (int a = 16; a < 64; a += 4) bus_wr(8'(a), 32'h0);
    for (int b = 0; b < 3; b++) bus_wr(8'(4*b), 32'hFFFF_FFFF);
    idle(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int b = 0; b < 3; b++) begin
      bus_rd(8'(4*b), d); chk("R1 status", d, 0);
    end
    for (int g = 1; g <= 3; g++)
      for (int b = 0; b < 3; b++) begin
        bus_rd(8'(16*g + 4*b), d); chk("R1 enable", d, 0);
      end
    chk("R1 irq", 32'(irq), 0);
    chk("R1 hint valid", 32'(hvld), 0);
  endtask

  task automatic t_capture();
    logic [31:0] d;
    fire(5);
    bus_rd(8'h00, d); chk("R2 set", d, 32'h20);
    idle(5);
    bus_rd(8'h00, d); chk("R2 sticky", d, 32'h20);
    chk("R6 masked line low", 32'(irq), 0);
    fire(70);
    bus_rd(8'h08, d); chk("R2 word2 bit6", d, 32'h40);
    bus_wr(8'h08, 32'h40);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    bus_wr(8'h00, ~32'h20);
    bus_rd(8'h00, d); chk("R3 zeros keep", d, 32'h20);
    bus_wr(8'h00, 32'h20);
    bus_rd(8'h00, d); chk("R3 one clears", d, 0);
  endtask

  task automatic t_enable_rw();
    logic [31:0] d;
    bus_wr(8'h24, 32'hA5A5_0F0F);
    bus_rd(8'h24, d); chk("R5 readback", d, 32'hA5A5_0F0F);
    bus_rd(8'h14, d); chk("R5 group0 word1 untouched", d, 0);
    bus_rd(8'h34, d); chk("R5 group2 word1 untouched", d, 0);
    bus_rd(8'h20, d); chk("R5 group1 word0 untouched", d, 0);
    bus_wr(8'h24, 32'h0);
  endtask

  task automatic t_irq_timing();
    bus_wr(8'h10, 32'h20);
    fire(5);
    chk("R6 one-cycle delay rise", 32'(irq), 0);
    idle(1);
    chk("R6 line0 high", 32'(irq), 1);
    bus_wr(8'h00, 32'h20);
    chk("R6 one-cycle delay fall", 32'(irq), 1);
    idle(1);
    chk("R6 line0 low", 32'(irq), 0);
  endtask

  task automatic t_mask_keeps();
    logic [31:0] d;
    fire(5);
    idle(1);
    chk("R7 line up before masking", 32'(irq), 1);
    bus_wr(8'h10, 32'h0);
    idle(1);
    chk("R7 masked line low", 32'(irq), 0);
    bus_rd(8'h00, d); chk("R7 status kept", d, 32'h20);
    clean();
  endtask

  task automatic t_index();
    logic [31:0] d;
    bus_wr(8'h10, (32'h1 << 9) | (32'h1 << 3));
    fire(9); fire(3);
    idle(1);
    chk("R8 lowest index line0", 32'(hidx[6:0]), 3);
    chk("R8 valid line0", 32'(hvld[0]), 1);
    bus_rd(8'h40, d); chk("R8 read index0", d, 32'h103);
    bus_wr(8'h10, 32'h1 << 9);
    idle(1);
    chk("R8 next index after disable", 32'(hidx[6:0]), 9);
    bus_wr(8'h38, 32'h1 << 17);
    fire(81);
    idle(1);
    chk("R8 line2 index", 32'(hidx[20:14]), 81);
    chk("R6 line2 high", 32'(irq[2]), 1);
    bus_wr(8'h28, 32'h1 << 17);
    idle(1);
    chk("R8 line1 high from word2", 32'(irq[1]), 1);
    chk("R8 line1 index invalid", 32'(hvld[1]), 0);
    bus_rd(8'h44, d); chk("R8 read index1 empty", d, 0);
    clean();
    chk("R8 all invalid after clean", 32'(hvld), 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    fire(35);
    @(negedge clk);
    addr = 8'h04; wdata = 32'h0000_000C; we = 1'b1; evt[34] = 1'b1;
    @(negedge clk);
    we = 1'b0; evt = '0;
    bus_rd(8'h04, d); chk("R4 set wins, other bit clears", d, 32'h4);
    bus_wr(8'h04, 32'h4);
    bus_rd(8'h04, d); chk("R4 later clear works", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_wr(8'h0C, 32'hFFFF_FFFF);
    bus_wr(8'h3C, 32'hFFFF_FFFF);
    bus_wr(8'h50, 32'hFFFF_FFFF);
    bus_rd(8'h0C, d); chk("R9 0x0C", d, 0);
    bus_rd(8'h3C, d); chk("R9 0x3C", d, 0);
    bus_rd(8'h4C, d); chk("R9 0x4C", d, 0);
    bus_rd(8'h50, d); chk("R9 0x50", d, 0);
    fire(1);
    bus_rd(8'h01, d); chk("R9 unaligned", d, 0);
    bus_wr(8'h00, 32'h2);
  endtask

  task automatic run_all();
    t_reset();
    t_capture();
    t_w1c();
    t_enable_rw();
    t_irq_timing();
    t_mask_keeps();
    t_index();
    t_collide();
    t_unmapped();
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; evt = '0; addr = '0; we = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule